// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block models a byte-wide static RAM in which every location has a nonvolatile shadow byte. Four active-low control pins select the operation: chip select, write strobe, output strobe and shadow strobe. The operations are read, write, copy of the whole RAM into the shadow (STORE), copy of the whole shadow back into the RAM (RECALL), and idle. The bulk copies are timed by cycle counters and walk the address space one location per clock. A busy flag is raised for the whole duration, and host reads and writes are refused while it is high.

Two digital supply flags stand in for the analog comparators. `vdd_trip_ok` is high while the supply is above the trigger level. `vdd_rst_ok` is high while the supply is above the lower reset level. An automatic RECALL runs after reset, which models power-on. It also runs after any excursion below the reset level, once the supply is back above the trigger level. A shallow dip that stays above the reset level causes no RECALL. A STORE request is ignored while the supply is below the trigger level.

Reads are registered: the byte appears on `dout` with `dout_en` high one clock after the read is sampled. Array depth and the three timing counts are parameters, so that simulations can use small values.

Top module: `nvram_ctrl`

## Requirements
- R1: A cycle sampled with ce_n=0, we_n=1, oe_n=0, nv_n=1 while idle returns the byte at `addr` on `dout` with `dout_en`=1 in the following cycle.
- R2: A cycle sampled with ce_n=0, we_n=0, nv_n=1 while idle writes `din` to `addr`, whatever the value of oe_n.
- R3: `dout_en` is high only in the cycle after a sampled read; any cycle with we_n=0, including a write whose strobe was already low when chip select fell, leaves `dout_en` low.
- R4: A STORE starts only after ce_n=0, we_n=0, oe_n=1, nv_n=0 has been sampled on INIT_CYC consecutive clocks. A shorter hold has no effect. Releasing any pin after the start does not abort the STORE.
- R5: A STORE keeps `busy` high for exactly STORE_CYC cycles and copies every RAM byte into the shadow.
- R6: Entering ce_n=0, we_n=1, oe_n=0, nv_n=0 while idle starts a RECALL. It keeps `busy` high for exactly RECALL_CYC cycles and copies every shadow byte into the RAM.
- R7: While `busy` is high, host reads give no output and host writes do not change the RAM.
- R8: A STORE request made while `vdd_trip_ok`=0 is ignored.
- R9: After reset is released, a RECALL runs automatically once `vdd_trip_ok`=1.
- R10: A drop of `vdd_trip_ok` alone causes no RECALL. A drop of `vdd_rst_ok` causes a RECALL once `vdd_trip_ok` returns high.
- R11: `standby` is high exactly when ce_n=1 and no STORE or RECALL is running, and it is high during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, models power-on |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| nv_n | input | 1 | Shadow transfer strobe, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data |
| vdd_trip_ok | input | 1 | Supply above trigger level |
| vdd_rst_ok | input | 1 | Supply above reset level |
| dout | output | 8 | Read data |
| dout_en | output | 1 | Drive enable for read data |
| busy | output | 1 | STORE or RECALL running |
| standby | output | 1 | Deselected and idle |

## Verification
The assertions assume that all control pins and supply flags are synchronous to `clk` and stable around the rising edge. They also assume that the supply flags are ordered: `vdd_trip_ok` is never high while `vdd_rst_ok` is low. The bench changes every input on the falling edge only. Whenever it lowers `vdd_rst_ok`, it lowers `vdd_trip_ok` first and raises it last, so the flags never contradict each other.

// File: rtl/nvram_pkg.sv
package nvram_pkg;
    typedef enum logic [2:0] {
        MD_IDLE,
        MD_READ,
        MD_WRITE,
        MD_RECALL,
        MD_STORE
    } mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_STORE,
        SQ_RECALL
    } seq_e;
endpackage

// File: rtl/nvram_decode.sv
module nvram_decode
    import nvram_pkg::*;
(
    input  logic  ce_n,
    input  logic  we_n,
    input  logic  oe_n,
    input  logic  nv_n,
    output mode_e mode
);
    always_comb begin
        mode = MD_IDLE;
        if (!ce_n) begin
            if (!we_n && nv_n)              mode = MD_WRITE;
            else if (!we_n && oe_n)         mode = MD_STORE;
            else if (we_n && !oe_n && nv_n) mode = MD_READ;
            else if (we_n && !oe_n)         mode = MD_RECALL;
        end
    end
endmodule

// File: rtl/nvram_mem.sv
module nvram_mem #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/nvram_seq.sv
module nvram_seq
    import nvram_pkg::*;
#(
    parameter int AW         = 10,
    parameter int STORE_CYC  = 2048,
    parameter int RECALL_CYC = 1100,
    parameter int INIT_CYC   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  mode_e         mode,
    input  logic          vdd_trip_ok,
    input  logic          vdd_rst_ok,
    input  logic [7:0]    rd_data,
    output seq_e          state,
    output logic          busy,
    output logic [AW-1:0] copy_ptr,
    output logic          store_copy,
    output logic          recall_copy,
    output logic [7:0]    dout,
    output logic          dout_en
);
    localparam int DEPTH   = 1 << AW;
    localparam int DUR_MAX = (STORE_CYC > RECALL_CYC) ? STORE_CYC : RECALL_CYC;
    localparam int CW      = $clog2(DUR_MAX + 1);
    localparam int IW      = $clog2(INIT_CYC + 1);

    typedef struct packed {
        seq_e          st;
        logic [CW-1:0] cnt;
        logic [IW-1:0] init;
        logic          lost;
        logic          rcl_prev;
        logic [7:0]    dout;
        logic          dout_en;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d          = seq_q;
        seq_d.rcl_prev = (mode == MD_RECALL);
        seq_d.lost     = seq_q.lost | !vdd_rst_ok;
        case (seq_q.st)
            SQ_IDLE: begin
                if (mode == MD_STORE && vdd_trip_ok) begin
                    if (seq_q.init == IW'(INIT_CYC - 1)) begin
                        seq_d.st   = SQ_STORE;
                        seq_d.cnt  = '0;
                        seq_d.init = '0;
                    end else begin
                        seq_d.init = seq_q.init + 1'b1;
                    end
                end else begin
                    seq_d.init = '0;
                end
                if (seq_q.lost && vdd_trip_ok && vdd_rst_ok) begin
                    seq_d.st   = SQ_RECALL;
                    seq_d.cnt  = '0;
                    seq_d.init = '0;
                    seq_d.lost = 1'b0;
                end else if (mode == MD_RECALL && !seq_q.rcl_prev) begin
                    seq_d.st   = SQ_RECALL;
                    seq_d.cnt  = '0;
                    seq_d.init = '0;
                end
            end
            SQ_STORE: begin
                if (seq_q.cnt == CW'(STORE_CYC - 1)) seq_d.st = SQ_IDLE;
                else seq_d.cnt = seq_q.cnt + 1'b1;
            end
            SQ_RECALL: begin
                if (seq_q.cnt == CW'(RECALL_CYC - 1)) seq_d.st = SQ_IDLE;
                else seq_d.cnt = seq_q.cnt + 1'b1;
            end
            default: seq_d.st = SQ_IDLE;
        endcase
        seq_d.dout_en = (mode == MD_READ) && (seq_q.st == SQ_IDLE)
                        && (seq_d.st == SQ_IDLE);
        seq_d.dout    = seq_d.dout_en ? rd_data : seq_q.dout;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q          <= '0;
            seq_q.st       <= SQ_IDLE;
            seq_q.lost     <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state       = seq_q.st;
    assign busy        = (seq_q.st != SQ_IDLE);
    assign copy_ptr    = seq_q.cnt[AW-1:0];
    assign store_copy  = (seq_q.st == SQ_STORE)  && (seq_q.cnt < CW'(DEPTH));
    assign recall_copy = (seq_q.st == SQ_RECALL) && (seq_q.cnt < CW'(DEPTH));
    assign dout        = seq_q.dout;
    assign dout_en     = seq_q.dout_en;
endmodule

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
    import nvram_pkg::*;
#(
    parameter int AW         = 10,
    parameter int STORE_CYC  = 2048,
    parameter int RECALL_CYC = 1100,
    parameter int INIT_CYC   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic          nv_n,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    din,
    input  logic          vdd_trip_ok,
    input  logic          vdd_rst_ok,
    output logic [7:0]    dout,
    output logic          dout_en,
    output logic          busy,
    output logic          standby
);
    mode_e         mode;
    seq_e          seq_st;
    logic [AW-1:0] copy_ptr;
    logic          store_copy;
    logic          recall_copy;
    logic          host_wr;
    logic [7:0]    ram_rdata;
    logic [7:0]    nv_rdata;

    nvram_decode u_dec (
        .ce_n (ce_n),
        .we_n (we_n),
        .oe_n (oe_n),
        .nv_n (nv_n),
        .mode (mode)
    );

    nvram_seq #(
        .AW         (AW),
        .STORE_CYC  (STORE_CYC),
        .RECALL_CYC (RECALL_CYC),
        .INIT_CYC   (INIT_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode        (mode),
        .vdd_trip_ok (vdd_trip_ok),
        .vdd_rst_ok  (vdd_rst_ok),
        .rd_data     (ram_rdata),
        .state       (seq_st),
        .busy        (busy),
        .copy_ptr    (copy_ptr),
        .store_copy  (store_copy),
        .recall_copy (recall_copy),
        .dout        (dout),
        .dout_en     (dout_en)
    );

    assign host_wr = (mode == MD_WRITE) && !busy;

    nvram_mem #(.AW(AW), .DW(8)) u_ram (
        .clk   (clk),
        .we    (host_wr | recall_copy),
        .waddr (recall_copy ? copy_ptr : addr),
        .wdata (recall_copy ? nv_rdata : din),
        .raddr (busy ? copy_ptr : addr),
        .rdata (ram_rdata)
    );

    nvram_mem #(.AW(AW), .DW(8)) u_shadow (
        .clk   (clk),
        .we    (store_copy),
        .waddr (copy_ptr),
        .wdata (ram_rdata),
        .raddr (copy_ptr),
        .rdata (nv_rdata)
    );

    assign standby = ce_n && !busy;
endmodule

// File: rtl/nvram_ctrl_chk.sv
module nvram_ctrl_chk
    import nvram_pkg::*;
#(
    parameter int STORE_CYC  = 2048,
    parameter int RECALL_CYC = 1100
) (
    input logic clk,
    input logic rst_n,
    input logic we_n,
    input logic vdd_trip_ok,
    input logic busy,
    input logic standby,
    input logic dout_en,
    input seq_e seq_st
);
    int unsigned run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= 0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= 0;
    end

    assert_out_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> $past(we_n));

    assert_no_out_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> !busy);

    assert_store_needs_supply_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_st == SQ_STORE && $past(seq_st) == SQ_IDLE) |-> $past(vdd_trip_ok));

    assert_run_length_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_len == STORE_CYC || run_len == RECALL_CYC));

    assert_standby_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> !busy);
endmodule

bind nvram_ctrl nvram_ctrl_chk #(
    .STORE_CYC  (STORE_CYC),
    .RECALL_CYC (RECALL_CYC)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_n        (we_n),
    .vdd_trip_ok (vdd_trip_ok),
    .busy        (busy),
    .standby     (standby),
    .dout_en     (dout_en),
    .seq_st      (seq_st)
);

// File: tb/nvram_ctrl_tb.sv
module nvram_ctrl_tb_top;
    localparam int AW         = 6;
    localparam int DEPTH      = 1 << AW;
    localparam int STORE_CYC  = 300;
    localparam int RECALL_CYC = 120;
    localparam int INIT_CYC   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, nv_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          vdd_trip_ok = 1'b1, vdd_rst_ok = 1'b1;
    logic [7:0]    dout;
    logic          dout_en, busy, standby;

    int n_tests = 0;
    int n_fail  = 0;
    int cur_run = 0;
    int last_run = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    nvram_ctrl #(
        .AW(AW), .STORE_CYC(STORE_CYC), .RECALL_CYC(RECALL_CYC), .INIT_CYC(INIT_CYC)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .nv_n(nv_n),
        .addr(addr), .din(din), .vdd_trip_ok(vdd_trip_ok), .vdd_rst_ok(vdd_rst_ok),
        .dout(dout), .dout_en(dout_en), .busy(busy), .standby(standby)
    );

    function automatic logic [7:0] pat1(int a);
        return 8'(a * 7 + 3);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // busy run length measured at falling edges
    always @(negedge clk) begin
        if (busy) cur_run <= cur_run + 1;
        else if (cur_run > 0) begin
            last_run <= cur_run;
            cur_run  <= 0;
        end
    end

    // monitor: pops expected read data
    always @(negedge clk) begin
        if (dout_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3 unexpected dout_en", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(dout == e, t, dout, e);
            end
        end
    end

    task automatic idle_bus();
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; nv_n = 1'b1;
    endtask

    task automatic wr(input int a, input logic [7:0] d, input logic g);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = g; nv_n = 1'b1;
        addr = AW'(a); din = d;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic rd(input int a, input logic [7:0] e, input string tag);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; nv_n = 1'b1;
        addr = AW'(a);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        idle_bus();
        @(negedge clk);
    endtask

    task automatic hold_store(input int n);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; nv_n = 1'b0;
        repeat (n) @(negedge clk);
        idle_bus();
    endtask

    task automatic pin_recall();
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; nv_n = 1'b0;
        @(negedge clk);
        idle_bus();
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // reset state, R11
        repeat (3) @(negedge clk);
        check(!busy && !dout_en && standby, "R11 reset state", {busy, dout_en, standby}, 3'b001);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy, "R9 power-up recall started", busy, 1);
        wait_idle();
        check(last_run == RECALL_CYC, "R9 power-up recall length", last_run, RECALL_CYC);

        // fill and read back, R1 R2
        for (int a = 0; a < DEPTH; a++) wr(a, pat1(a), 1'b1);
        wr(9, pat1(9), 1'b0);  // R2 oe_n don't care
        rd(0, pat1(0), "R1 read addr 0");
        rd(9, pat1(9), "R2 write with oe low");
        rd(DEPTH - 1, pat1(DEPTH - 1), "R1 read top addr");

        // R3: write strobe low as chip select falls
        @(negedge clk);
        we_n = 1'b0; oe_n = 1'b0; addr = 6'd3; din = pat1(3);
        @(negedge clk);
        ce_n = 1'b0;
        @(negedge clk);
        check(!dout_en, "R3 no drive while write strobe low", dout_en, 0);
        idle_bus();

        // R4 short hold ignored
        hold_store(INIT_CYC - 1);
        repeat (3) @(negedge clk);
        check(!busy, "R4 short store hold", busy, 0);

        // R4 R5 full store, released early
        hold_store(INIT_CYC + 2);
        check(busy, "R4 store runs after release", busy, 1);
        // R7 blocked access during store
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b1; oe_n = 1'b0; nv_n = 1'b1; addr = 6'd1;
        @(negedge clk);
        check(!dout_en, "R7 read blocked while busy", dout_en, 0);
        idle_bus();
        wr(0, 8'hEE, 1'b1);
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        check(!standby, "R11 no standby while busy", standby, 0);
        wait_idle();
        check(last_run == STORE_CYC, "R5 store length", last_run, STORE_CYC);
        check(standby, "R11 standby after store", standby, 1);
        rd(0, pat1(0), "R7 blocked write left RAM");

        // overwrite RAM, then recall from pins, R6
        for (int a = 0; a < DEPTH; a++) wr(a, ~pat1(a), 1'b1);
        rd(1, ~pat1(1), "R2 overwrite");
        pin_recall();
        check(busy, "R6 recall started", busy, 1);
        wait_idle();
        check(last_run == RECALL_CYC, "R6 recall length", last_run, RECALL_CYC);
        rd(0, pat1(0), "R6 restored addr 0");
        rd(33, pat1(33), "R5 stored addr 33");
        rd(DEPTH - 1, pat1(DEPTH - 1), "R5 stored top addr");

        // R8 store under low supply
        wr(5, 8'h55, 1'b1);
        vdd_trip_ok = 1'b0;
        hold_store(INIT_CYC + 4);
        @(negedge clk);
        check(!busy, "R8 store ignored low supply", busy, 0);
        vdd_trip_ok = 1'b1;
        repeat (4) @(negedge clk);
        check(!busy, "R10 no recall after shallow dip", busy, 0);
        pin_recall();
        wait_idle();
        rd(5, pat1(5), "R8 shadow unchanged");

        // R10 shallow dip keeps RAM
        wr(5, 8'h77, 1'b1);
        vdd_trip_ok = 1'b0;
        repeat (5) @(negedge clk);
        vdd_trip_ok = 1'b1;
        repeat (5) @(negedge clk);
        check(!busy, "R10 shallow dip no recall", busy, 0);
        rd(5, 8'h77, "R10 RAM kept after shallow dip");

        // R10 deep drop then recall
        vdd_trip_ok = 1'b0;
        @(negedge clk);
        vdd_rst_ok = 1'b0;
        repeat (3) @(negedge clk);
        vdd_rst_ok = 1'b1;
        repeat (2) @(negedge clk);
        check(!busy, "R10 no recall before trigger level", busy, 0);
        vdd_trip_ok = 1'b1;
        @(negedge clk);
        check(busy, "R10 recall after deep drop", busy, 1);
        wait_idle();
        check(last_run == RECALL_CYC, "R10 recall length", last_run, RECALL_CYC);
        rd(5, pat1(5), "R10 RAM restored");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R1 all reads answered", exp_q.size(), 0);
        summary();
        $finish;
    end
endmodule